// File: doc/BRIEF.md
# Multi-Queue Packet Ready Tracker

This block sits beside the storage of a sixteen-queue buffer. It keeps a count of the whole packets held in each queue. The writer marks the first word of a packet with a start marker and the last word with an end marker. When the end marker of an opened packet is written, the target queue's count rises by one. When a word carrying the end marker is read, the count of the read queue falls by one. For the queue currently selected on the read side, the block drives an active-low ready flag. It also drives an "available" output, which is true only when that flag is asserted and the read side reports valid output data.

The tracking function is enabled by a mode input that is captured while reset is held. With the mode low, the ready flag stays inactive, nothing is counted and no errors are raised. With the mode high, the block also polices the write side. It raises one sticky error bit in any of these cases:
- the writer tries to leave a queue while a packet is still open;
- a start marker arrives inside an open packet;
- an end marker arrives with no packet open;
- a completion would overflow a counter;
- an end-marker read would underflow a counter.

Storage, pointers and threshold flags are handled elsewhere. The surrounding buffer is expected to run both ports 36 bits wide whenever the mode is high.

Top module: `pkt_ready_tracker`

## Requirements
- R1: `pkt_mode_i` is captured on every clock edge while `rst_n` is low and is held afterwards. When the captured mode is 0, `pkt_rdy_n_o` stays 1, `pkt_avail_o` stays 0 and `proto_err_o` stays 0, whatever is written or read.
- R2: `pkt_rdy_n_o` is 0 exactly when the captured mode is 1 and the queue named by `rd_q_i` holds at least one complete packet. It follows `rd_q_i` combinationally, and it reflects a completed write from the clock edge on which that write is taken.
- R3: A packet is complete when its end marker is written after its start marker. A single word carrying both markers with no packet open is also a complete packet. Each completion adds one to the count of its queue.
- R4: A read with `rd_en_i`=1 and `rd_eop_i`=1 subtracts one from the count of queue `rd_q_i`.
- R5: `pkt_avail_o` is 1 exactly when `pkt_rdy_n_o` is 0 and `rd_valid_i` is 1.
- R6: While a packet is open, a write naming a different queue sets `proto_err_o`. The switch is ignored: the word, including its end marker, goes to the queue that opened the packet.
- R7: A start marker written while a packet is open sets `proto_err_o`. The open packet stays open.
- R8: An end marker written without a start marker while no packet is open sets `proto_err_o` and changes no count.
- R9: An end-marker read from a queue whose count is 0 sets `proto_err_o`, and the count stays 0.
- R10: A completion on a queue whose count is at its maximum (2^CNT_W-1, which is 63 by default) sets `proto_err_o`, and the count stays at the maximum.
- R11: Once set, `proto_err_o` stays 1 until the next reset.
- R12: A completion and an end-marker read on the same queue in the same cycle leave that queue's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_mode_i | input | 1 | Packet-mode select, captured during reset |
| wr_en_i | input | 1 | Write strobe |
| wr_q_i | input | 4 | Write queue number |
| wr_sop_i | input | 1 | Start-of-packet marker on the written word |
| wr_eop_i | input | 1 | End-of-packet marker on the written word |
| rd_en_i | input | 1 | Read strobe |
| rd_q_i | input | 4 | Read queue number |
| rd_eop_i | input | 1 | End-of-packet marker on the word being read |
| rd_valid_i | input | 1 | Output-valid indication from the read side |
| pkt_rdy_n_o | output | 1 | Active-low packet-ready flag for the read queue |
| pkt_avail_o | output | 1 | Ready flag asserted together with valid output |
| proto_err_o | output | 1 | Sticky protocol-error bit |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before operation starts. They also assume that `pkt_mode_i` only matters during reset. The counter properties rely on the read side presenting an end marker only on words that actually exist in the queue; violations of that rule are exactly the underflow case. The stimulus holds reset for two edges and changes the mode only inside reset. It changes inputs one time unit after a rising edge, so every input is stable at the next edge. Every deliberate protocol violation is followed by a fresh reset, so each error case starts from a clear error bit.

// File: rtl/pkt_trk_pkg.sv
// Package: shared types for the packet ready tracker.
// Assumes nothing beyond a single clock domain.
package pkt_trk_pkg;
    // Write-side packet framing state.
    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_OPEN = 1'b1
    } wr_state_t;
endpackage

// File: rtl/pkt_wr_ctrl.sv
// Write-side framing control. It tracks whether a packet is open and which
// queue owns it, decides which queue a completion counts against, and
// flags framing violations. Assumes mode_i is constant outside reset.
module pkt_wr_ctrl
    import pkt_trk_pkg::*;
#(
    parameter int NQ = 16,
    localparam int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          wr_en_i,
    input  logic [QW-1:0] wr_q_i,
    input  logic          wr_sop_i,
    input  logic          wr_eop_i,
    output logic          inc_v_o,
    output logic [QW-1:0] inc_q_o,
    output logic          err_o
);
    wr_state_t     state_q;
    logic [QW-1:0] lock_q;
    logic          is_open;
    logic          bad_switch, bad_sop, bad_eop, act;

    // Decode the framing decision for the current write word.
    always_comb begin
        is_open    = (state_q == WS_OPEN);
        act        = mode_i && wr_en_i;
        bad_switch = act && is_open && (wr_q_i != lock_q);
        bad_sop    = act && is_open && wr_sop_i;
        bad_eop    = act && !is_open && wr_eop_i && !wr_sop_i;
        inc_v_o    = act && wr_eop_i && (is_open || wr_sop_i);
        inc_q_o    = is_open ? lock_q : wr_q_i;
        err_o      = bad_switch || bad_sop || bad_eop;
    end

    // Advance the open/closed state and capture the owning queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            lock_q  <= '0;
        end else if (act) begin
            if (is_open && wr_eop_i) begin
                state_q <= WS_IDLE;
            end else if (!is_open && wr_sop_i && !wr_eop_i) begin
                state_q <= WS_OPEN;
                lock_q  <= wr_q_i;
            end
        end
    end

    // R6: an open packet keeps its owner until its end marker is written.
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_OPEN && !(wr_en_i && wr_eop_i))
        |=> (state_q == WS_OPEN && $stable(lock_q)));

    // R3: the end marker of an open packet closes it.
    p_close_on_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_OPEN && mode_i && wr_en_i && wr_eop_i) |=> (state_q == WS_IDLE));
endmodule

// File: rtl/pkt_cnt_bank.sv
// Bank of per-queue complete-packet counters. It counts up on completion,
// down on an end-marker read, saturates at both ends and reports the
// blocked cases as overflow and underflow pulses.
// Assumes at most one completion and one read per cycle.
module pkt_cnt_bank #(
    parameter int NQ    = 16,
    parameter int CNT_W = 6,
    localparam int QW   = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_v_i,
    input  logic [QW-1:0]    inc_q_i,
    input  logic             dec_v_i,
    input  logic [QW-1:0]    dec_q_i,
    output logic [CNT_W-1:0] cnt_o [NQ],
    output logic             ovf_o,
    output logic             unf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic same_q;

    // Flag completions and reads that the saturating counters refuse.
    always_comb begin
        same_q = inc_v_i && dec_v_i && (inc_q_i == dec_q_i);
        ovf_o  = inc_v_i && !same_q && (cnt_o[inc_q_i] == CNT_MAX);
        unf_o  = dec_v_i && !same_q && (cnt_o[dec_q_i] == '0);
    end

    for (genvar i = 0; i < NQ; i++) begin : g_q
        logic up, dn;
        assign up = inc_v_i && (inc_q_i == QW'(i));
        assign dn = dec_v_i && (dec_q_i == QW'(i));

        // Saturating up/down count of complete packets in queue i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_o[i] <= '0;
            end else if (up && !dn && cnt_o[i] != CNT_MAX) begin
                cnt_o[i] <= cnt_o[i] + 1'b1;
            end else if (dn && !up && cnt_o[i] != '0) begin
                cnt_o[i] <= cnt_o[i] - 1'b1;
            end
        end

        // R9: a read with an empty count never wraps.
        p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (dn && !up && cnt_o[i] == '0) |=> (cnt_o[i] == '0));

        // R10: a completion at the maximum holds the maximum.
        p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (up && !dn && cnt_o[i] == CNT_MAX) |=> (cnt_o[i] == CNT_MAX));

        // R3: an unblocked completion raises the count by exactly one.
        p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (up && !dn && cnt_o[i] != CNT_MAX) |=> (cnt_o[i] == $past(cnt_o[i]) + 1'b1));

        // R12: a completion and a read in the same cycle cancel.
        p_cancel_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (up && dn) |=> $stable(cnt_o[i]));
    end
endmodule

// File: rtl/pkt_ready_tracker.sv
// Top level: captures the mode during reset, joins the write framing
// control with the counter bank, and drives the ready flag, the available
// output and the sticky error bit. Assumes one clock and a synchronous
// active-low reset held for at least one edge.
module pkt_ready_tracker #(
    parameter int NQ    = 16,
    parameter int CNT_W = 6,
    localparam int QW   = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_mode_i,
    input  logic          wr_en_i,
    input  logic [QW-1:0] wr_q_i,
    input  logic          wr_sop_i,
    input  logic          wr_eop_i,
    input  logic          rd_en_i,
    input  logic [QW-1:0] rd_q_i,
    input  logic          rd_eop_i,
    input  logic          rd_valid_i,
    output logic          pkt_rdy_n_o,
    output logic          pkt_avail_o,
    output logic          proto_err_o
);
    logic             mode_q;
    logic             inc_v, dec_v, wr_err, ovf, unf;
    logic [QW-1:0]    inc_q;
    logic [CNT_W-1:0] cnt [NQ];

    // Capture the operating mode while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= pkt_mode_i;
    end

    pkt_wr_ctrl #(.NQ(NQ)) u_wr (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_q),
        .wr_en_i(wr_en_i), .wr_q_i(wr_q_i),
        .wr_sop_i(wr_sop_i), .wr_eop_i(wr_eop_i),
        .inc_v_o(inc_v), .inc_q_o(inc_q), .err_o(wr_err)
    );

    assign dec_v = mode_q && rd_en_i && rd_eop_i;

    pkt_cnt_bank #(.NQ(NQ), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc_v_i(inc_v), .inc_q_i(inc_q),
        .dec_v_i(dec_v), .dec_q_i(rd_q_i),
        .cnt_o(cnt), .ovf_o(ovf), .unf_o(unf)
    );

    // Hold any protocol violation until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  proto_err_o <= 1'b0;
        else if (wr_err || ovf || unf) proto_err_o <= 1'b1;
    end

    // Ready flag for the read queue and its qualified form.
    always_comb begin
        pkt_rdy_n_o = !(mode_q && (cnt[rd_q_i] != '0));
        pkt_avail_o = !pkt_rdy_n_o && rd_valid_i;
    end

    // R1: the captured mode never changes outside reset.
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

    // R11: the error bit is sticky.
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);

    // R1: in standard mode no violation is ever recorded.
    p_std_no_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |=> !proto_err_o);
endmodule

// File: tb/pkt_ready_tracker_tb.sv
module pkt_ready_tracker_tb;
    localparam int NQ = 16;
    localparam int QW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_mode = 1'b1;
    logic wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [QW-1:0] wr_q = '0, rd_q = '0;
    logic rd_en = 1'b0, rd_eop = 1'b0, rd_valid = 1'b0;
    logic rdy_n, avail, err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  rdy_n;
        logic  avail;
        logic  err;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pkt_ready_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_mode_i(pkt_mode),
        .wr_en_i(wr_en), .wr_q_i(wr_q), .wr_sop_i(wr_sop), .wr_eop_i(wr_eop),
        .rd_en_i(rd_en), .rd_q_i(rd_q), .rd_eop_i(rd_eop), .rd_valid_i(rd_valid),
        .pkt_rdy_n_o(rdy_n), .pkt_avail_o(avail), .proto_err_o(err)
    );

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rdy_n !== e.rdy_n || avail !== e.avail || err !== e.err) begin
                errors++;
                $display("FAIL %s: rdy_n/avail/err actual %b%b%b expected %b%b%b",
                         e.tag, rdy_n, avail, err, e.rdy_n, e.avail, e.err);
            end
        end
    end

    task automatic idle();
        wr_en = 0; wr_sop = 0; wr_eop = 0; rd_en = 0; rd_eop = 0;
    endtask

    task automatic do_reset(input logic m);
        idle();
        rst_n = 0; pkt_mode = m;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    // One cycle of write and/or read activity.
    task automatic step(input logic we, input logic [QW-1:0] wq, input logic s,
                        input logic e, input logic re, input logic [QW-1:0] rq,
                        input logic reo);
        wr_en = we; wr_q = wq; wr_sop = s; wr_eop = e;
        rd_en = re; rd_q = rq; rd_eop = reo;
        @(posedge clk);
        #1 idle();
    endtask

    // Driver: present a read selection and push the expected outputs.
    task automatic expect_out(input logic [QW-1:0] rq, input logic v, input logic er,
                              input logic ea, input logic ee, input string tag);
        exp_t e;
        rd_q = rq; rd_valid = v;
        e.rdy_n = er; e.avail = ea; e.err = ee; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1 rd_valid = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1);
        expect_out(0, 0, 1, 0, 0, "R1 reset state");
        // Three-word packet into queue 3.
        step(1, 3, 1, 0, 0, 0, 0);
        expect_out(3, 0, 1, 0, 0, "R3 open packet not ready");
        step(1, 3, 0, 0, 0, 0, 0);
        step(1, 3, 0, 1, 0, 0, 0);
        expect_out(3, 0, 0, 0, 0, "R2 R3 q3 ready");
        expect_out(0, 0, 1, 0, 0, "R2 q0 not ready");
        expect_out(3, 1, 0, 1, 0, "R5 ready and valid");
        expect_out(0, 1, 1, 0, 0, "R5 valid without ready");
        // Single-word packet in queue 5.
        step(1, 5, 1, 1, 0, 0, 0);
        expect_out(5, 0, 0, 0, 0, "R3 single word packet");
        step(0, 0, 0, 0, 1, 3, 1);
        expect_out(3, 0, 1, 0, 0, "R4 read eop empties q3");
        step(1, 5, 1, 1, 1, 5, 1);
        expect_out(5, 0, 0, 0, 0, "R12 simultaneous keeps count 1");
        step(0, 0, 0, 0, 1, 5, 1);
        expect_out(5, 0, 1, 0, 0, "R12 then one read empties q5");

        // R7: start marker inside open packet.
        do_reset(1);
        step(1, 2, 1, 0, 0, 0, 0);
        step(1, 2, 1, 0, 0, 0, 0);
        expect_out(2, 0, 1, 0, 1, "R7 sop inside packet");
        step(1, 2, 0, 1, 0, 0, 0);
        expect_out(2, 0, 0, 0, 1, "R7 packet stayed open");

        // R6: switch during open packet is ignored.
        do_reset(1);
        step(1, 4, 1, 0, 0, 0, 0);
        step(1, 7, 0, 0, 0, 0, 0);
        expect_out(4, 0, 1, 0, 1, "R6 switch flagged");
        step(1, 7, 0, 1, 0, 0, 0);
        expect_out(4, 0, 0, 0, 1, "R6 eop went to q4");
        expect_out(7, 0, 1, 0, 1, "R6 q7 untouched");

        // R8: orphan end marker.
        do_reset(1);
        step(1, 1, 0, 1, 0, 0, 0);
        expect_out(1, 0, 1, 0, 1, "R8 orphan eop");
        expect_out(1, 0, 1, 0, 1, "R11 error held");

        // R9: underflow.
        do_reset(1);
        step(0, 0, 0, 0, 1, 6, 1);
        expect_out(6, 0, 1, 0, 1, "R9 underflow flagged");
        step(0, 0, 0, 0, 1, 6, 1);
        step(0, 0, 0, 0, 1, 6, 1);
        step(1, 6, 1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 6, 1);
        expect_out(6, 0, 1, 0, 1, "R9 count stayed zero");

        // R10: saturation at 63.
        do_reset(1);
        repeat (63) step(1, 8, 1, 1, 0, 0, 0);
        expect_out(8, 0, 0, 0, 0, "R10 full without error");
        step(1, 8, 1, 1, 0, 0, 0);
        expect_out(8, 0, 0, 0, 1, "R10 overflow flagged");
        repeat (62) step(0, 0, 0, 0, 1, 8, 1);
        expect_out(8, 0, 0, 0, 1, "R10 one packet left");
        step(0, 0, 0, 0, 1, 8, 1);
        expect_out(8, 0, 1, 0, 1, "R10 held at max");
        do_reset(1);
        expect_out(8, 0, 1, 0, 0, "R11 reset clears error");

        // R1: standard mode.
        do_reset(0);
        step(1, 0, 1, 1, 0, 0, 0);
        expect_out(0, 1, 1, 0, 0, "R1 std mode no ready");
        step(1, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 9, 1);
        expect_out(9, 0, 1, 0, 0, "R1 std mode no error");

        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule